// File: doc/BRIEF.md
# Dual In-Order Queue with Deferred Data and Per-Slot Ready Bits

This block buffers work on its way to a neural-network compute engine. It keeps two logical FIFO queues in one shared data store. The store is split into two equal halves, one per queue. A producer reserves a slot at the tail of a chosen queue before the data for that slot exists, and receives a slot tag in return. The data arrives later as a separate write addressed by that tag. The writes may come in any order. Each write marks its slot as ready.

The consumer always reads from one queue at a time, the active queue. It takes entries strictly in reservation order. The head entry leaves only once its ready bit is set. If the consumer goes a fixed number of consecutive cycles without taking an entry, and the other queue holds something, the active queue flips to the other one. A producer that allocates into a full queue is held off by valid/ready backpressure.

Top module: `dualq_ready_buffer`

## Requirements
- R1: After reset, `deq_valid` is 0 and `active_q` is 0. `alloc_ready` is 1 for both queues, and the offered tag is index 0 of the selected queue.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both 1. The tag offered on `alloc_tag` has the queue ID in its MSB (bit 3 at default parameters) and the slot index in the low `IDX_W` bits. Successive accepted allocations to one queue get consecutive indices, which wrap modulo `DEPTH`.
- R3: Once a queue holds `DEPTH` reserved slots that have not been dequeued, `alloc_ready` is 0 whenever that queue is selected. It stays 1 when the other queue is selected. An `alloc_valid` pulse toward the full queue reserves nothing.
- R4: A write (`wr_valid`) stores `wr_data` in the slot named by `wr_tag` and sets that slot's ready bit.
- R5: `deq_valid` is 1 only when the active queue is non-empty and its head slot is ready. A later slot that is written first does not make the queue dequeueable.
- R6: Entries leave each queue in reservation order. `deq_data` and `deq_tag` give the head slot's data and tag.
- R7: A dequeue clears the slot's ready bit. When that slot is reserved again, it is not dequeueable until it has been written again.
- R8: The two queues are independent. A ready entry in the inactive queue is not presented, and activity on one queue does not change the other's pointers or data.
- R9: The active queue flips at the clock edge that ends the 16th (`IDLE_LIMIT`) consecutive cycle without a dequeue, provided the other queue is non-empty at that edge.
- R10: There is no flip while the other queue is empty. Any dequeue restarts the idle count.
- R11: A flip also restarts the idle count. Flipping back takes another full run of `IDLE_LIMIT` idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Producer requests a slot |
| alloc_qsel | input | 1 | Queue to reserve in |
| alloc_ready | output | 1 | Selected queue has room |
| alloc_tag | output | TAG_W | Tag of the slot being offered (queue ID, index) |
| wr_valid | input | 1 | Deferred data write |
| wr_tag | input | TAG_W | Slot to write |
| wr_data | input | DATA_W | Data for that slot |
| deq_valid | output | 1 | Active-queue head is present and ready |
| deq_ready | input | 1 | Consumer takes the head entry |
| deq_data | output | DATA_W | Head entry data |
| deq_tag | output | TAG_W | Head entry tag |
| active_q | output | 1 | Queue currently served |

## Verification
The data path is tried in three ways. Writes arrive in reverse order, which shows that the block gates on the head slot rather than on any ready slot. A queue is filled to capacity and then drained, which covers backpressure, wrap-around of the indices and the clearing of ready bits on reuse. A ready entry sits only in the inactive queue, which shows that the queues are kept apart. Queue switching is timed cycle by cycle from a known dequeue. The timing runs cover three cases: an uninterrupted idle run, a run broken by a dequeue, and a run with the other queue empty. Together they separate a correct threshold from an off-by-one error, from a count that does not restart, and from a flip into an empty queue.

// File: rtl/dq_pkg.sv
package dq_pkg;

  localparam int unsigned NUM_Q = 2;

  // Queue served when the active one is left.
  function automatic logic q_other(input logic q);
    return ~q;
  endfunction

endpackage

// File: rtl/dq_queue_ctrl.sv
module dq_queue_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W-1:0] head_idx,
  output logic             full,
  output logic             empty,
  output logic [IDX_W:0]   occupancy
);

  // The extra top bit is a lap marker that tells full from empty.
  logic [IDX_W:0] head_q, tail_q;

  function automatic logic [IDX_W:0] ptr_step(input logic [IDX_W:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [IDX_W:0] ptr_gap(input logic [IDX_W:0] t,
                                             input logic [IDX_W:0] h);
    return t - h;
  endfunction

  assign tail_idx  = tail_q[IDX_W-1:0];
  assign head_idx  = head_q[IDX_W-1:0];
  assign occupancy = ptr_gap(tail_q, head_q);
  assign empty     = (occupancy == '0);
  assign full      = (occupancy == (IDX_W+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push) tail_q <= ptr_step(tail_q);
      if (pop)  head_q <= ptr_step(head_q);
    end
  end

endmodule

// File: rtl/dq_slot_store.sv
module dq_slot_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned SLOTS = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [TAG_W-1:0]  clr_tag,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_rdy,
  output logic [SLOTS-1:0]  rdy_vec
);

  logic [DATA_W-1:0] mem [SLOTS];
  logic [SLOTS-1:0]  rdy_q;

  assign rdy_vec = rdy_q;
  assign rd_data = mem[rd_tag];
  assign rd_rdy  = rdy_q[rd_tag];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_tag] <= wr_data;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_rdy
    always_ff @(posedge clk) begin
      if (!rst_n)
        rdy_q[s] <= 1'b0;
      else if (wr_en && wr_tag == TAG_W'(s))
        rdy_q[s] <= 1'b1;
      else if (clr_en && clr_tag == TAG_W'(s))
        rdy_q[s] <= 1'b0;
    end
  end

endmodule

// File: rtl/dq_idle_switch.sv
module dq_idle_switch #(
  parameter int unsigned IDLE_LIMIT = 16,
  localparam int unsigned CW = $clog2(IDLE_LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deq_fire,
  input  logic          other_nonempty,
  output logic          active_q,
  output logic [CW-1:0] idle_cnt,
  output logic          switch_evt
);

  localparam logic [CW-1:0] CNT_TOP = CW'(IDLE_LIMIT - 1);

  logic          act_q;
  logic [CW-1:0] cnt_q;

  // Counts up and stops at the top value.
  function automatic logic [CW-1:0] idle_step(input logic [CW-1:0] c);
    return (c == CNT_TOP) ? c : c + 1'b1;
  endfunction

  assign active_q   = act_q;
  assign idle_cnt   = cnt_q;
  assign switch_evt = !deq_fire && (cnt_q == CNT_TOP) && other_nonempty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (deq_fire) begin
      cnt_q <= '0;
    end else if (switch_evt) begin
      act_q <= dq_pkg::q_other(act_q);
      cnt_q <= '0;
    end else begin
      cnt_q <= idle_step(cnt_q);
    end
  end

endmodule

// File: rtl/dualq_ready_buffer.sv
module dualq_ready_buffer #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned IDLE_LIMIT = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned TAG_W = IDX_W + 1,
  localparam int unsigned CW    = $clog2(IDLE_LIMIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_qsel,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              deq_valid,
  input  logic              deq_ready,
  output logic [DATA_W-1:0] deq_data,
  output logic [TAG_W-1:0]  deq_tag,
  output logic              active_q
);

  localparam int unsigned NQ = dq_pkg::NUM_Q;

  // Internal events, named so that the checker can see them.
  logic             alloc_fire;
  logic             deq_fire;
  logic             switch_evt;
  logic             other_nonempty;
  logic             head_rdy;
  logic [CW-1:0]    idle_cnt;
  logic [NQ-1:0]    q_full, q_empty, q_push, q_pop;
  logic [IDX_W-1:0] tail_idx [NQ];
  logic [IDX_W-1:0] head_idx [NQ];
  logic [IDX_W:0]   q_occ    [NQ];
  logic [(1<<TAG_W)-1:0] rdy_vec;

  function automatic logic [TAG_W-1:0] make_tag(input logic q,
                                                input logic [IDX_W-1:0] idx);
    return {q, idx};
  endfunction

  assign alloc_ready = !q_full[alloc_qsel];
  assign alloc_tag   = make_tag(alloc_qsel, tail_idx[alloc_qsel]);
  assign alloc_fire  = alloc_valid && alloc_ready;

  assign deq_tag   = make_tag(active_q, head_idx[active_q]);
  assign deq_valid = !q_empty[active_q] && head_rdy;
  assign deq_fire  = deq_valid && deq_ready;

  assign other_nonempty = !q_empty[dq_pkg::q_other(active_q)];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign q_push[q] = alloc_fire && (alloc_qsel == 1'(q));
    assign q_pop[q]  = deq_fire && (active_q == 1'(q));

    dq_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push[q]),
      .pop       (q_pop[q]),
      .tail_idx  (tail_idx[q]),
      .head_idx  (head_idx[q]),
      .full      (q_full[q]),
      .empty     (q_empty[q]),
      .occupancy (q_occ[q])
    );
  end

  dq_slot_store #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_valid),
    .wr_tag  (wr_tag),
    .wr_data (wr_data),
    .clr_en  (deq_fire),
    .clr_tag (deq_tag),
    .rd_tag  (deq_tag),
    .rd_data (deq_data),
    .rd_rdy  (head_rdy),
    .rdy_vec (rdy_vec)
  );

  dq_idle_switch #(.IDLE_LIMIT(IDLE_LIMIT)) u_sw (
    .clk            (clk),
    .rst_n          (rst_n),
    .deq_fire       (deq_fire),
    .other_nonempty (other_nonempty),
    .active_q       (active_q),
    .idle_cnt       (idle_cnt),
    .switch_evt     (switch_evt)
  );

endmodule

// File: rtl/dq_checker.sv
module dq_checker #(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned IDLE_LIMIT = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned TAG_W = IDX_W + 1,
  localparam int unsigned CW    = $clog2(IDLE_LIMIT)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  alloc_valid,
  input logic                  alloc_ready,
  input logic                  alloc_qsel,
  input logic                  wr_valid,
  input logic [TAG_W-1:0]      wr_tag,
  input logic                  deq_valid,
  input logic                  deq_ready,
  input logic [TAG_W-1:0]      deq_tag,
  input logic                  active_q,
  input logic [CW-1:0]         idle_cnt,
  input logic [1:0]            q_empty,
  input logic [IDX_W:0]        occ0,
  input logic [IDX_W:0]        occ1,
  input logic [(1<<TAG_W)-1:0] rdy_vec
);

  logic [IDX_W:0] sel_occ;
  assign sel_occ = alloc_qsel ? occ1 : occ0;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |-> (sel_occ < (IDX_W+1)'(DEPTH)));

  // R4
  write_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> rdy_vec[$past(wr_tag)]);

  // R5
  deq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> !q_empty[active_q]);

  // R7
  deq_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && deq_ready) |=> !rdy_vec[$past(deq_tag)]);

  // R9
  switch_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |->
      ($past(idle_cnt) == CW'(IDLE_LIMIT - 1) && !$past(deq_valid && deq_ready)));

  // R10
  switch_target_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> !$past(q_empty[~active_q]));

endmodule

bind dualq_ready_buffer dq_checker #(.DEPTH(DEPTH), .IDLE_LIMIT(IDLE_LIMIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_qsel  (alloc_qsel),
  .wr_valid    (wr_valid),
  .wr_tag      (wr_tag),
  .deq_valid   (deq_valid),
  .deq_ready   (deq_ready),
  .deq_tag     (deq_tag),
  .active_q    (active_q),
  .idle_cnt    (idle_cnt),
  .q_empty     (q_empty),
  .occ0        (q_occ[0]),
  .occ1        (q_occ[1]),
  .rdy_vec     (rdy_vec)
);

// File: tb/tb_dualq_ready_buffer.sv
module tb_dualq_ready_buffer;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int IDLE   = 16;
  localparam int TAG_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_valid = 1'b0;
  logic              alloc_qsel = 1'b0;
  logic              alloc_ready;
  logic [TAG_W-1:0]  alloc_tag;
  logic              wr_valid = 1'b0;
  logic [TAG_W-1:0]  wr_tag = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              deq_valid;
  logic              deq_ready = 1'b0;
  logic [DATA_W-1:0] deq_data;
  logic [TAG_W-1:0]  deq_tag;
  logic              active_q;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dualq_ready_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDLE_LIMIT(IDLE)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_qsel(alloc_qsel),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_data(wr_data),
    .deq_valid(deq_valid), .deq_ready(deq_ready),
    .deq_data(deq_data), .deq_tag(deq_tag), .active_q(active_q)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; alloc_valid = 0; wr_valid = 0; deq_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_alloc(input logic q, output logic [TAG_W-1:0] tag);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_qsel = q;
    #1 tag = alloc_tag;
    check_eq("R2 alloc accepted", 32'(alloc_ready), 1);
    @(posedge clk); #1 alloc_valid = 1'b0;
  endtask

  task automatic do_write(input logic [TAG_W-1:0] tag, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_tag = tag; wr_data = d;
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic do_deq(input string req, input logic [31:0] exp_d);
    @(negedge clk);
    deq_ready = 1'b1;
    #1 check_eq(req, 32'(deq_valid), 1);
    check_eq(req, deq_data, exp_d);
    @(posedge clk); #1 deq_ready = 1'b0;
  endtask

  task automatic wait_active(input logic q);
    for (int i = 0; i < 40; i++) begin
      if (active_q == q) break;
      @(posedge clk); #1;
    end
    check_eq("R8 reached queue", 32'(active_q), 32'(q));
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    #1;
    check_eq("R1 deq_valid", 32'(deq_valid), 0);
    check_eq("R1 active_q", 32'(active_q), 0);
    alloc_qsel = 0; #1;
    check_eq("R1 ready q0", 32'(alloc_ready), 1);
    check_eq("R1 tag q0", 32'(alloc_tag), 0);
    alloc_qsel = 1; #1;
    check_eq("R1 ready q1", 32'(alloc_ready), 1);
    check_eq("R1 tag q1", 32'(alloc_tag), 32'h8);
  endtask

  // R4 R5 R6: out-of-order writes
  task automatic t_order();
    logic [TAG_W-1:0] t [3];
    do_reset();
    for (int i = 0; i < 3; i++) begin
      do_alloc(0, t[i]);
      check_eq("R2 index", 32'(t[i]), 32'(i));
    end
    do_write(t[2], 32'hC2);
    do_write(t[1], 32'hC1);
    @(negedge clk); #1 check_eq("R5 head not ready", 32'(deq_valid), 0);
    do_write(t[0], 32'hC0);
    do_deq("R6 first", 32'hC0);
    do_deq("R6 second", 32'hC1);
    @(negedge clk); #1 check_eq("R6 tag", 32'(deq_tag), 32'h2);
    do_deq("R4 third", 32'hC2);
    @(negedge clk); #1 check_eq("R5 drained", 32'(deq_valid), 0);
  endtask

  // R3 R2 R7: fill, backpressure, wrap
  task automatic t_full();
    logic [TAG_W-1:0] tg;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(0, tg);
      check_eq("R2 fill index", 32'(tg), 32'(i));
    end
    @(negedge clk); alloc_qsel = 0; #1;
    check_eq("R3 full q0", 32'(alloc_ready), 0);
    alloc_qsel = 1; #1;
    check_eq("R3 q1 free", 32'(alloc_ready), 1);
    alloc_qsel = 0; alloc_valid = 1;
    @(posedge clk); #1 alloc_valid = 0;
    for (int i = 0; i < DEPTH; i++) do_write(TAG_W'(i), 32'h100 + i);
    for (int i = 0; i < DEPTH; i++) do_deq("R6 full drain", 32'h100 + i);
    @(negedge clk); #1 check_eq("R3 nothing extra", 32'(deq_valid), 0);
    do_alloc(0, tg);
    check_eq("R2 wrap index", 32'(tg), 0);
    @(negedge clk); #1 check_eq("R7 reused slot not ready", 32'(deq_valid), 0);
    do_write(tg, 32'h55);
    do_deq("R7 reused slot", 32'h55);
  endtask

  // R8
  task automatic t_indep();
    logic [TAG_W-1:0] a, b;
    do_reset();
    do_alloc(0, a);
    do_alloc(1, b);
    check_eq("R8 q1 tag", 32'(b), 32'h8);
    do_write(b, 32'hB1);
    @(negedge clk); #1 check_eq("R8 inactive hidden", 32'(deq_valid), 0);
    wait_active(1);
    do_deq("R8 q1 data", 32'hB1);
    do_write(a, 32'hA0);
    wait_active(0);
    do_deq("R8 q0 data", 32'hA0);
  endtask

  // R9 R11
  task automatic t_switch();
    logic [TAG_W-1:0] a0, a1, b0;
    do_reset();
    do_alloc(0, a0); do_alloc(0, a1); do_write(a0, 1); do_write(a1, 2);
    do_alloc(1, b0); do_write(b0, 3);
    do_deq("R9 setup", 1);
    for (int i = 1; i < IDLE; i++) begin
      @(posedge clk); #1;
      if (i == IDLE - 1) check_eq("R9 no early flip", 32'(active_q), 0);
    end
    @(posedge clk); #1 check_eq("R9 flip at limit", 32'(active_q), 1);
    for (int i = 1; i < IDLE; i++) begin
      @(posedge clk); #1;
      if (i == IDLE - 1) check_eq("R11 restart held", 32'(active_q), 1);
    end
    @(posedge clk); #1 check_eq("R11 flip back", 32'(active_q), 0);
  endtask

  // R10
  task automatic t_noswitch();
    logic [TAG_W-1:0] a0, a1, b0;
    do_reset();
    do_alloc(0, a0); do_write(a0, 7);
    repeat (40) @(posedge clk);
    #1 check_eq("R10 other empty", 32'(active_q), 0);
    do_deq("R10 q0", 7);
    do_alloc(0, a0); do_alloc(0, a1); do_write(a0, 8); do_write(a1, 9);
    do_alloc(1, b0); do_write(b0, 10);
    do_deq("R10 deq one", 8);
    repeat (10) @(posedge clk);
    do_deq("R10 deq two", 9);
    for (int i = 1; i < IDLE; i++) begin
      @(posedge clk); #1;
      if (i == IDLE - 1) check_eq("R10 count restarted", 32'(active_q), 0);
    end
    @(posedge clk); #1 check_eq("R10 eventual flip", 32'(active_q), 1);
  endtask

  initial begin
    t_reset();
    t_order();
    t_full();
    t_indep();
    t_switch();
    t_noswitch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule